// File: doc/BRIEF.md
# Counted-Loop Branch-and-Add Unit

This unit executes the counted-loop instruction of an integer core. In the cycle the instruction issues, it adds the first operand (the step) into the second operand (the counter). It also decides a delayed branch from a one-bit loop-condition flag and computes where that branch goes. The register file, operand fetch and delay-slot sequencing live outside the unit. The unit is given the instruction word, its PC and the two operand values. It returns the register write (index, data, enable), the taken indication and the target.

The flag lives inside the unit. The branch decision always uses the flag value left by the previous loop instruction. The same instruction then writes a new flag for the next one. For a non-negative step, the new flag is the carry out of the addition. For a negative step, the new flag is set when the signed result is still non-negative. A countdown that has already passed zero therefore clears the flag, and the following loop instruction falls through.

Top module: `cntloop_unit`

## Requirements
- R1: An instruction is a loop instruction when `issue_vld` is 1 and bits 31:26 equal 0x2D. Any other cycle gives `wb_en`=0 and `br_taken`=0, and leaves the flag unchanged.
- R2: For a loop instruction, `br_taken` equals the flag value held before that instruction (the value left by the previous loop instruction).
- R3: For a loop instruction, `wb_en`=1, `wb_idx` equals bits 25:21 and `wb_data` equals `src1_val + src2_val` modulo 2^32. The step register index is bits 15:11.
- R4: When `src1_val` bit 31 is 1, the new flag (`cond_next`) is 1 exactly when bit 31 of the 32-bit sum is 0.
- R5: When `src1_val` bit 31 is 0, the new flag is the carry out of the unsigned 32-bit addition.
- R6: The 16-bit word offset is formed from instruction bits 20:16 as its upper 5 bits and bits 10:0 as its lower 11 bits, then sign-extended.
- R7: `br_target` equals `pc_cur + 4 + offset*4` modulo 2^32, for every loop instruction, whether or not it is taken.
- R8: A step of -1 applied to a counter of -1 gives flag 0, so the next loop instruction is not taken. A countdown from a counter of 3 with step -1 gives flags 1,1,1,0.
- R9: After reset the flag is 0, so the first loop instruction is not taken.
- R10: Outputs are combinational in the issue cycle. The new flag is stored at the clock edge that ends that cycle. `cond_next` shows the flag the unit will hold after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| issue_vld | input | 1 | An instruction issues this cycle |
| instr_word | input | 32 | Issued instruction word |
| pc_cur | input | 32 | Address of the issued instruction |
| src1_val | input | 32 | Step operand value (register at bits 15:11) |
| src2_val | input | 32 | Counter operand value (register at bits 25:21) |
| wb_en | output | 1 | Write counter register this cycle |
| wb_idx | output | 5 | Counter register index |
| wb_data | output | 32 | Updated counter value |
| cond_next | output | 1 | Flag value held after this cycle |
| br_taken | output | 1 | Delayed branch taken |
| br_target | output | 32 | Branch target address |

## Verification
Two things meet in every issue cycle of back-to-back loop instructions: the branch decision reads the stored flag, and the flag rewrite replaces it. The bench issues loop instructions on consecutive cycles across a sweep of step and counter corner values. Each `br_taken` is compared with the flag that the bench predicted from the previous operands, and each `cond_next` is compared with the sign or carry rule for the current ones. Intervening non-loop and idle cycles are placed between loop instructions to show that the flag survives them unchanged.

// File: rtl/cntloop_pkg.sv
package cntloop_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned OFF_HI_W = 5;
  localparam int unsigned OFF_LO_W = OFF_W - OFF_HI_W;
  localparam logic [5:0]  OPC_LOOP = 6'h2D;

  typedef struct packed {
    logic             hit;
    logic [4:0]       step_idx;
    logic [4:0]       cnt_idx;
    logic [OFF_W-1:0] woff;
  } loop_dec_t;
endpackage

// File: rtl/cntloop_rst_sync.sv
module cntloop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cntloop_decode.sv
module cntloop_decode
  import cntloop_pkg::*;
(
  input  logic               issue_vld,
  input  logic [INSTR_W-1:0] instr_word,
  output loop_dec_t          dec
);
  always_comb begin
    dec.hit      = issue_vld && (instr_word[31:26] == OPC_LOOP);
    dec.cnt_idx  = instr_word[25:21];
    dec.step_idx = instr_word[15:11];
    dec.woff     = {instr_word[16 +: OFF_HI_W], instr_word[0 +: OFF_LO_W]};
  end
endmodule

// File: rtl/cntloop_adder.sv
module cntloop_adder #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] step,
  input  logic [XLEN-1:0] cnt,
  output logic [XLEN-1:0] sum,
  output logic            cond
);
  logic [XLEN:0] wide;

  always_comb begin
    wide = {1'b0, step} + {1'b0, cnt};
    sum  = wide[XLEN-1:0];
    if (step[XLEN-1]) cond = ~wide[XLEN-1];
    else              cond = wide[XLEN];
  end
endmodule

// File: rtl/cntloop_target.sv
module cntloop_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] woff,
  output logic [XLEN-1:0]  target
);
  localparam int unsigned EXT_W = XLEN - OFF_W - 2;
  logic [XLEN-1:0] byte_off;

  always_comb begin
    byte_off = {{EXT_W{woff[OFF_W-1]}}, woff, 2'b00};
    target   = pc + XLEN'(4) + byte_off;
  end
endmodule

// File: rtl/cntloop_flag_reg.sv
module cntloop_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic flag_in,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = load_en ? flag_in : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(flag_q)); // R1
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (flag_q == $past(flag_in))); // R10
endmodule

// File: rtl/cntloop_unit.sv
module cntloop_unit
  import cntloop_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_vld,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [XLEN-1:0]    pc_cur,
  input  logic [XLEN-1:0]    src1_val,
  input  logic [XLEN-1:0]    src2_val,
  output logic               wb_en,
  output logic [4:0]         wb_idx,
  output logic [XLEN-1:0]    wb_data,
  output logic               cond_next,
  output logic               br_taken,
  output logic [XLEN-1:0]    br_target
);
  logic      rst_n_sync;
  loop_dec_t dec;
  logic      rule_flag;
  logic      flag_q;

  cntloop_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  cntloop_decode u_dec (
    .issue_vld(issue_vld), .instr_word(instr_word), .dec(dec));

  cntloop_adder #(.XLEN(XLEN)) u_add (
    .step(src1_val), .cnt(src2_val), .sum(wb_data), .cond(rule_flag));

  cntloop_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc(pc_cur), .woff(dec.woff), .target(br_target));

  cntloop_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n_sync), .load_en(dec.hit),
    .flag_in(rule_flag), .flag_q(flag_q));

  always_comb begin
    wb_en     = dec.hit;
    wb_idx    = dec.cnt_idx;
    br_taken  = dec.hit && flag_q;
    cond_next = dec.hit ? rule_flag : flag_q;
  end

  AST_TAKE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    br_taken |-> wb_en); // R1
  AST_TAKEN_PREV: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wb_en && $past(wb_en)) |-> (br_taken == $past(cond_next))); // R2
  AST_CARRY_RULE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wb_en && !src1_val[XLEN-1]) |-> (cond_next == (wb_data < src1_val))); // R5
  AST_NEG_RULE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wb_en && src1_val[XLEN-1] && src2_val[XLEN-1] && wb_data[XLEN-1]) |-> !cond_next); // R4
  AST_COUNTDOWN_STOP: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wb_en && (&src1_val) && (&src2_val)) |-> !cond_next); // R8
  AST_TARGET_ALIGN: assert property (@(posedge clk) disable iff (!rst_n_sync)
    wb_en |-> (br_target[1:0] == pc_cur[1:0])); // R7
endmodule

// File: tb/cntloop_unit_test.sv
module cntloop_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        issue_vld;
  logic [31:0] instr_word, pc_cur, src1_val, src2_val;
  logic        wb_en, cond_next, br_taken;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data, br_target;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_flag;
  bit   done = 0;

  cntloop_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr_word(instr_word),
    .pc_cur(pc_cur), .src1_val(src1_val), .src2_val(src2_val),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .cond_next(cond_next),
    .br_taken(br_taken), .br_target(br_target));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rc,
                                     input logic [4:0] rs, input logic [15:0] off);
    return {op, rc, off[15:11], rs, off[10:0]};
  endfunction

  // Drive one cycle and compare all outputs against the requirements.
  task automatic issue(input logic v, input logic [31:0] iw, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b);
    logic        hit;
    logic [32:0] w;
    logic        rule;
    logic [15:0] off;
    logic [31:0] tgt;
    @(negedge clk);
    issue_vld = v; instr_word = iw; pc_cur = pc; src1_val = a; src2_val = b;
    #1;
    hit  = v && (iw[31:26] == 6'h2D);
    w    = {1'b0, a} + {1'b0, b};
    rule = a[31] ? ~w[31] : w[32];
    off  = {iw[20:16], iw[10:0]};
    tgt  = pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    chk("R1 wb_en", {31'b0, wb_en}, {31'b0, hit});
    if (hit) begin
      chk("R2 br_taken", {31'b0, br_taken}, {31'b0, exp_flag});
      chk("R3 wb_idx", {27'b0, wb_idx}, {27'b0, iw[25:21]});
      chk("R3 wb_data", wb_data, w[31:0]);
      chk(a[31] ? "R4 cond_next" : "R5 cond_next", {31'b0, cond_next}, {31'b0, rule});
      chk("R6_R7 br_target", br_target, tgt);
      exp_flag = rule;
    end else begin
      chk("R1 br_taken", {31'b0, br_taken}, 32'd0);
      chk("R1 cond_next", {31'b0, cond_next}, {31'b0, exp_flag});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [12];
    vals = '{32'h0, 32'h1, 32'h2, 32'h7fff_ffff, 32'h8000_0000, 32'h8000_0001,
             32'hffff_fffe, 32'hffff_ffff, 32'h0000_1234, 32'hfedc_ba98,
             32'h4000_0000, 32'hc000_0000};
    rst_n = 1'b0; issue_vld = 1'b0; instr_word = '0; pc_cur = '0;
    src1_val = '0; src2_val = '0; exp_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset flag is 0 -> first loop instruction not taken
    issue(1'b1, mk(6'h2D, 5'd3, 5'd4, 16'h0010), 32'h1000, 32'h0, 32'h0);
    chk("R9 first loop not taken", {31'b0, br_taken}, 32'd0);

    // R2 R3 R4 R5 R10: back-to-back sweep of corner operand pairs
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        issue(1'b1, mk(6'h2D, 5'(i + j), 5'(i), 16'(i * 4099 + j * 257)),
              32'h2000 + 32'(i * 64 + j * 4), vals[i], vals[j]);

    // R6 R7: offset field sweep, taken and not taken alike
    for (int h = 0; h < 32; h++)
      for (int k = 0; k < 5; k++) begin
        logic [10:0] lo;
        lo = (k == 0) ? 11'h000 : (k == 1) ? 11'h001 : (k == 2) ? 11'h3ff :
             (k == 3) ? 11'h400 : 11'h7ff;
        issue(1'b1, mk(6'h2D, 5'd7, 5'd9, {h[4:0], lo}), 32'h8000_0000 + 32'(h * 4),
              32'(k), 32'hffff_fff0 + 32'(h));
      end

    // R1: set flag to 1, then non-loop opcode and idle cycle must not touch it
    issue(1'b1, mk(6'h2D, 5'd1, 5'd2, 16'h0), 32'h0, 32'h1, 32'hffff_ffff);
    chk("R5 carry sets flag", {31'b0, cond_next}, 32'd1);
    issue(1'b1, mk(6'h2C, 5'd1, 5'd2, 16'h0), 32'h40, 32'hffff_ffff, 32'hffff_ffff);
    issue(1'b0, mk(6'h2D, 5'd1, 5'd2, 16'h0), 32'h44, 32'hffff_ffff, 32'hffff_ffff);
    issue(1'b1, mk(6'h2D, 5'd1, 5'd2, 16'h0), 32'h48, 32'h0, 32'h0);
    chk("R1 flag survived non-loop cycles", {31'b0, br_taken}, 32'd1);

    // R8: spent countdown stops
    issue(1'b1, mk(6'h2D, 5'd5, 5'd6, 16'hfffe), 32'h100, 32'hffff_ffff, 32'hffff_ffff);
    chk("R8 spent countdown flag", {31'b0, cond_next}, 32'd0);
    issue(1'b1, mk(6'h2D, 5'd5, 5'd6, 16'hfffe), 32'h104, 32'hffff_ffff, 32'hffff_fffe);
    chk("R8 following loop falls through", {31'b0, br_taken}, 32'd0);

    // R8: countdown from 3 with step -1 gives flags 1,1,1,0
    begin
      logic [31:0] cnt;
      logic [3:0]  fl;
      cnt = 32'd3;
      for (int s = 0; s < 4; s++) begin
        issue(1'b1, mk(6'h2D, 5'd5, 5'd6, 16'hfffe), 32'h200, 32'hffff_ffff, cnt);
        fl[s] = cond_next;
        cnt = wb_data;
      end
      chk("R8 countdown flag sequence", {28'b0, fl}, 32'h7);
      issue(1'b1, mk(6'h2D, 5'd5, 5'd6, 16'hfffe), 32'h200, 32'hffff_ffff, cnt);
      chk("R8 countdown exit not taken", {31'b0, br_taken}, 32'd0);
    end

    @(negedge clk);
    issue_vld = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule